// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers up to fifteen interrupt request lines for a small processor. Each source keeps one bit in each of three state registers: enable, pending and software-raise. A fourth, write-only register drops pending bits. A rising edge on a request line latches its pending bit. The controller then offers the processor one request: the highest-numbered source that is enabled and has its pending or software-raise bit set. It presents that source as a 4-bit level and as a trap code.

The source number is also its priority, so source 15 wins over every other source. The trap code is the source number plus 0x10. On a typical processor, sources 2 and 3 come from the serial channels, 4 to 7 from external pins, and 8 and 9 from the timers.

Once the processor takes a request, it returns the serviced level on an acknowledge strobe. That strobe drops both the pending bit and the software-raise bit of the serviced source. Software reads and writes the registers through a simple single-cycle bus. Reads are combinational and writes take effect at the next clock edge.

Top module: `irqc_top`

## Requirements
- R1: During and after reset, the enable, pending and software-raise registers read 0, `irq_level` is 0 and `irq_trap` is 0.
- R2: A 0-to-1 transition on `irq_in[n]` (n from 1 to 15), seen between two clock edges, sets pending bit n at the next edge. A line held high sets its bit only once, so after a clear it stays clear until the line falls and rises again. `irq_in[0]` never sets anything.
- R3: Enable bit n set to 1 lets source n compete for the request. Set to 0, it blocks source n without changing its pending or software-raise bit.
- R4: `irq_level` is the highest n in 1..15 whose enable bit is 1 and whose pending or software-raise bit is 1. When no source qualifies, it is 0.
- R5: `irq_trap` equals `irq_level` + 0x10 when `irq_level` is nonzero, and 0 otherwise.
- R6: A bus write to offset 0x9C clears each pending bit whose data bit is 1. Zero data bits leave their pending bits unchanged. Offset 0x9C reads as 0.
- R7: A bus write to offset 0x98 loads the software-raise register. Any source with its software-raise bit set requests exactly as a pending source would. The register reads back at 0x98.
- R8: `ack_valid` high with `ack_level` = L in 1..15 clears pending bit L and software-raise bit L at the next edge. An acknowledge with level 0 changes nothing.
- R9: If a new rising edge of source n arrives in the same cycle as a clear write or an acknowledge for n, the edge wins and pending bit n ends up set.
- R10: The bus decodes the enable register at offset 0x90, pending at 0x94 (read only; writes are ignored), software-raise at 0x98 and clear at 0x9C. Bit 0 and bits 31:16 of every register read 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high and `bus_wr` is low |
| irq_in | input | 16 | Request lines, bit n for source n, bit 0 unused |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Winning source number, 0 when idle |
| irq_trap | output | 8 | Trap code of the winning source, 0 when idle |

## Verification
The hardest case to reach is the collision between a fresh rising edge and a clear write or acknowledge for the same source. It only arises when the line's low-to-high step and the bus or acknowledge strobe fall in exactly the same clock cycle. To reach it, the bench first drops the line for a cycle so that a real edge is pending. It then drives the edge together with the clear write, or with the acknowledge, from the same inactive clock phase, and reads the pending register back over the bus. A second hard case is a line held high across a clear. The bench keeps the line asserted while writing the clear register and then confirms that the bit does not come back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Which register a bus offset selects
    typedef enum logic [2:0] {
        RS_NONE,
        RS_ENABLE,
        RS_PEND,
        RS_RAISE,
        RS_DROP
    } regsel_t;

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_in,
    input  logic [W-1:0] keep,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = req_in;
        rise   = req_in & ~prev_q & keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // A reported edge needs the line high now
    AST_RISE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |-> ((rise & req_in) == rise)); // R2
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int                 NUM_SRC    = 15,
    parameter int                 ADDR_W     = 8,
    parameter int                 DATA_W     = 32,
    parameter int                 LVL_W      = 4,
    parameter logic [ADDR_W-1:0]  OFF_ENABLE = 8'h90,
    parameter logic [ADDR_W-1:0]  OFF_PEND   = 8'h94,
    parameter logic [ADDR_W-1:0]  OFF_RAISE  = 8'h98,
    parameter logic [ADDR_W-1:0]  OFF_DROP   = 8'h9C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC:0]   rise,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [NUM_SRC:0]   enable_vec,
    output logic [NUM_SRC:0]   pend_vec,
    output logic [NUM_SRC:0]   raise_vec
);
    localparam int V = NUM_SRC + 1;
    localparam logic [V-1:0] VALID = {{NUM_SRC{1'b1}}, 1'b0};

    typedef struct packed {
        logic [V-1:0] enable;
        logic [V-1:0] pend;
        logic [V-1:0] raise;
    } st_t;

    st_t          s_d, s_q;
    regsel_t      rsel;
    logic [V-1:0] wdata_v;
    logic [V-1:0] drop_bits;
    logic [V-1:0] ack_bits;
    logic [V-1:0] rd_v;
    logic         unused_hi;

    assign wdata_v   = bus_wdata[V-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:V];

    always_comb begin
        if      (bus_addr == OFF_ENABLE) rsel = RS_ENABLE;
        else if (bus_addr == OFF_PEND)   rsel = RS_PEND;
        else if (bus_addr == OFF_RAISE)  rsel = RS_RAISE;
        else if (bus_addr == OFF_DROP)   rsel = RS_DROP;
        else                             rsel = RS_NONE;
    end

    always_comb begin
        ack_bits = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            ack_bits[i] = ack_valid && (ack_level == LVL_W'(i));
        end
        drop_bits = (bus_sel && bus_wr && rsel == RS_DROP) ? wdata_v : '0;
    end

    always_comb begin
        s_d = s_q;
        if (bus_sel && bus_wr && rsel == RS_ENABLE) begin
            s_d.enable = wdata_v & VALID;
        end
        if (bus_sel && bus_wr && rsel == RS_RAISE) begin
            s_d.raise = wdata_v & VALID;
        end else begin
            s_d.raise = s_q.raise & ~ack_bits;
        end
        s_d.pend = ((s_q.pend & ~drop_bits & ~ack_bits) | rise) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_v = '0;
        if (bus_sel && !bus_wr) begin
            case (rsel)
                RS_ENABLE: rd_v = s_q.enable;
                RS_PEND:   rd_v = s_q.pend;
                RS_RAISE:  rd_v = s_q.raise;
                default:   rd_v = '0;
            endcase
        end
        bus_rdata = {{(DATA_W-V){1'b0}}, rd_v};
    end

    assign enable_vec = s_q.enable;
    assign pend_vec   = s_q.pend;
    assign raise_vec  = s_q.raise;

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level != '0 && int'(ack_level) <= NUM_SRC && !rise[ack_level])
        |=> !s_q.pend[$past(ack_level)]); // R8
    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((s_q.pend & $past(rise)) == $past(rise))); // R9
    AST_BIT0_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pend[0] && !s_q.enable[0] && !s_q.raise[0]); // R10
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NUM_SRC = 15,
    parameter int LVL_W   = 4
) (
    input  logic [NUM_SRC:0]  req,
    output logic [LVL_W-1:0]  level
);
    always_comb begin
        level = '0;
        for (int i = 0; i <= NUM_SRC; i++) begin
            if (req[i]) level = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int          NUM_SRC   = 15,
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          TRAP_W    = 8,
    parameter int          TRAP_BASE = 16,
    parameter int          LVL_W     = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC:0]   irq_in,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [LVL_W-1:0]   irq_level,
    output logic [TRAP_W-1:0]  irq_trap
);
    localparam logic [NUM_SRC:0] KEEP = {{NUM_SRC{1'b1}}, 1'b0};

    logic [NUM_SRC:0] rise;
    logic [NUM_SRC:0] enable_vec, pend_vec, raise_vec;
    logic [NUM_SRC:0] active;

    irqc_edge #(.W(NUM_SRC + 1)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (irq_in),
        .keep   (KEEP),
        .rise   (rise)
    );

    irqc_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LVL_W   (LVL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rise       (rise),
        .ack_valid  (ack_valid),
        .ack_level  (ack_level),
        .enable_vec (enable_vec),
        .pend_vec   (pend_vec),
        .raise_vec  (raise_vec)
    );

    assign active = (pend_vec | raise_vec) & enable_vec;

    irqc_prio #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_prio (
        .req   (active),
        .level (irq_level)
    );

    always_comb begin
        irq_trap = (irq_level != '0) ? TRAP_W'(TRAP_BASE + int'(irq_level)) : '0;
    end

    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> enable_vec[irq_level]); // R3
    AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (pend_vec[irq_level] || raise_vec[irq_level])); // R4
    AST_IDLE_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (((pend_vec | raise_vec) & enable_vec) == '0)); // R4
    AST_NONE_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        ((((pend_vec | raise_vec) & enable_vec) >> irq_level) >> 1) == '0); // R4
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [15:0] irq_in;
    logic        ack_valid;
    logic [3:0]  ack_level;
    logic [3:0]  irq_level;
    logic [7:0]  irq_trap;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irqc_top u_irqc_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .ack_valid(ack_valid), .ack_level(ack_level),
        .irq_level(irq_level), .irq_trap(irq_trap)
    );

    typedef struct packed {
        logic [15:0] irq;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        ack;
        logic [3:0]  ack_lvl;
        logic [3:0]  exp_lvl;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t TBL [NVEC] = '{
        '{16'h0000, 1'b1, 8'h90, 32'h0000FFFE, 1'b0, 4'd0,  4'd0},  // R3 enable all
        '{16'h0008, 1'b0, 8'h00, 32'h0,        1'b0, 4'd0,  4'd3},  // R2 edge on 3
        '{16'h0108, 1'b0, 8'h00, 32'h0,        1'b0, 4'd0,  4'd8},  // R4 8 beats 3
        '{16'h0000, 1'b0, 8'h00, 32'h0,        1'b1, 4'd8,  4'd3},  // R8 ack 8
        '{16'h0000, 1'b1, 8'h98, 32'h00008000, 1'b0, 4'd0,  4'd15}, // R7 raise 15
        '{16'h0000, 1'b1, 8'h90, 32'h00007FFE, 1'b0, 4'd0,  4'd3},  // R3 block 15
        '{16'h0000, 1'b1, 8'h9C, 32'h00000008, 1'b0, 4'd0,  4'd0},  // R6 drop 3
        '{16'h0000, 1'b1, 8'h90, 32'h0000FFFE, 1'b0, 4'd0,  4'd15}, // R3 unblock 15
        '{16'h0000, 1'b0, 8'h00, 32'h0,        1'b1, 4'd15, 4'd0},  // R8 ack raise
        '{16'h0002, 1'b0, 8'h00, 32'h0,        1'b0, 4'd0,  4'd1},  // R2 edge on 1
        '{16'h1002, 1'b0, 8'h00, 32'h0,        1'b0, 4'd0,  4'd12}, // R4 12 beats 1
        '{16'h1002, 1'b1, 8'h9C, 32'h00001000, 1'b0, 4'd0,  4'd1},  // R6 drop 12 held
        '{16'h0000, 1'b0, 8'h00, 32'h0,        1'b1, 4'd0,  4'd1},  // R8 ack level 0
        '{16'h0000, 1'b1, 8'h9C, 32'h00000002, 1'b0, 4'd0,  4'd0}   // R6 drop 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
        ack_valid = 1'b0; ack_level = 4'd0;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ack(input logic [3:0] l);
        ack_valid = 1'b1; ack_level = l;
        @(negedge clk);
        idle_inputs();
    endtask

    function automatic logic [7:0] trap_of(input logic [3:0] l);
        return (l == 4'd0) ? 8'h00 : 8'h10 + {4'h0, l};
    endfunction

    task automatic check_reset_state();
        logic [31:0] rd;
        bus_read(8'h90, rd); chk("R1 enable", rd, 32'h0);
        bus_read(8'h94, rd); chk("R1 pending", rd, 32'h0);
        bus_read(8'h98, rd); chk("R1 raise", rd, 32'h0);
        chk("R1 level", {28'h0, irq_level}, 32'h0);
        chk("R1 trap", {24'h0, irq_trap}, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0;
        irq_in = 16'h0;
        idle_inputs();
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            irq_in    = TBL[k].irq;
            bus_sel   = TBL[k].wr;
            bus_wr    = TBL[k].wr;
            bus_addr  = TBL[k].addr;
            bus_wdata = TBL[k].data;
            ack_valid = TBL[k].ack;
            ack_level = TBL[k].ack_lvl;
            @(negedge clk);
            idle_inputs();
            chk($sformatf("R4 level step %0d", k), {28'h0, irq_level}, {28'h0, TBL[k].exp_lvl});
            chk($sformatf("R5 trap step %0d", k), {24'h0, irq_trap}, {24'h0, trap_of(TBL[k].exp_lvl)});
        end

        // R10 decode and read masks
        bus_write(8'h90, 32'hFFFF_FFFF);
        bus_read(8'h90, rd);  chk("R10 enable bits", rd, 32'h0000FFFE);
        bus_read(8'h9C, rd);  chk("R6 drop reads 0", rd, 32'h0);
        bus_read(8'hA0, rd);  chk("R10 unmapped", rd, 32'h0);
        bus_write(8'h94, 32'h0000FFFE);
        bus_read(8'h94, rd);  chk("R10 pending not writable", rd, 32'h0);
        chk("R10 level after pending write", {28'h0, irq_level}, 32'h0);

        // R2 held-high line and bit 0
        irq_in = 16'h0021;
        @(negedge clk);
        bus_read(8'h94, rd);  chk("R2 edge sets 5 not 0", rd, 32'h00000020);
        bus_write(8'h9C, 32'h00000020);
        @(negedge clk);
        bus_read(8'h94, rd);  chk("R2 held line stays clear", rd, 32'h0);
        irq_in = 16'h0000;
        @(negedge clk);

        // R9 edge collides with a drop write
        irq_in = 16'h0040;
        bus_write(8'h9C, 32'h00000040);
        bus_read(8'h94, rd);  chk("R9 edge beats drop", rd, 32'h00000040);
        irq_in = 16'h0000;
        @(negedge clk);
        // R9 edge collides with an acknowledge
        irq_in = 16'h0040;
        ack(4'd6);
        bus_read(8'h94, rd);  chk("R9 edge beats ack", rd, 32'h00000040);
        irq_in = 16'h0000;

        // R6 zero bits leave others alone
        irq_in = 16'h0010;
        @(negedge clk);
        bus_read(8'h94, rd);  chk("R2 edge on 4", rd, 32'h00000050);
        bus_write(8'h9C, 32'h00000010);
        bus_read(8'h94, rd);  chk("R6 partial drop", rd, 32'h00000040);
        chk("R4 level 6", {28'h0, irq_level}, 32'd6);
        chk("R5 trap 0x16", {24'h0, irq_trap}, 32'h16);
        irq_in = 16'h0000;

        // R7 raise register
        bus_write(8'h98, 32'h00000204);
        bus_read(8'h98, rd);  chk("R7 raise readback", rd, 32'h00000204);
        chk("R7 raised 9 wins", {28'h0, irq_level}, 32'd9);
        chk("R5 trap 0x19", {24'h0, irq_trap}, 32'h19);

        // R8 acknowledge drops raise bits
        ack(4'd9);
        bus_read(8'h98, rd);  chk("R8 ack drops raise 9", rd, 32'h00000004);
        bus_read(8'h94, rd);  chk("R8 pending untouched", rd, 32'h00000040);
        chk("R8 level back to 6", {28'h0, irq_level}, 32'd6);
        ack(4'd6);
        bus_read(8'h94, rd);  chk("R8 ack drops pending 6", rd, 32'h0);
        chk("R8 level 2 from raise", {28'h0, irq_level}, 32'd2);

        // R3 blocking keeps state
        bus_write(8'h90, 32'h0);
        chk("R3 blocked level", {28'h0, irq_level}, 32'd0);
        bus_read(8'h98, rd);  chk("R3 raise kept", rd, 32'h00000004);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule